// File: doc/BRIEF.md
# Two-Wire Controller Register Front End

This block is the software-facing register file of a two-wire serial controller. It sits on a simple 16-bit peripheral bus that carries a byte address, an access size code, write and read strobes and write data. It answers with registered read data and a registered error pulse. Behind the bus it holds eight ordinary configuration registers and two sticky status registers that hardware events set and software clears by writing ones. It also mirrors two read-only status words and exposes a one-entry transmit holding register and a one-entry receive holding register to the serial engine.

Each register has its own access rule: read/write, write-one-to-clear, read-only, or write-only data port. Any access that is not 16 bits wide, or that lands on no defined register, is dropped and flagged on the error output. An interrupt line reports whether any unmasked interrupt status bit is set. The serial engine side is reduced to plain ports, so a bench or a neighbouring block can play the bit engine.

Top module: `tw_reg_front`

## Requirements
- R1: Slot n (n = 0..11) sits at byte offset 4·n in this order: clock divider, control, slave control, slave status, slave address, master control, master status, master address, interrupt status, interrupt mask, FIFO control, FIFO status. The data ports sit at 0x80 (8-bit transmit), 0x84 (16-bit transmit), 0x88 (8-bit receive) and 0x8C (16-bit receive).
- R2: bus_size encodes 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits. Only code 1 is legal. Any other code gives a one-cycle bus_err pulse after the access, changes no state and returns read data 0.
- R3: An access to an offset that is not a defined register gives a one-cycle bus_err pulse after the access, changes no state and returns read data 0. A misaligned offset counts as undefined.
- R4: The clock divider, control, slave control, slave address, master control, master address, interrupt mask and FIFO control registers read back the last value written to them.
- R5: In the interrupt status register, hw_int_set sets bits. A software write of 1 clears a bit and a write of 0 leaves it unchanged.
- R6: In the master status register, bits 11:0 behave like R5, using hw_mstat_set. Bits 15:12 show hw_mstat_live one cycle late: bit 15 is bus busy, bit 14 is clock-line sense, bit 13 is data-line sense and bit 12 is transfer in progress. Writes and hw_mstat_set never change bits 15:12.
- R7: When a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R8: Slave status and FIFO status read hw_sstat and hw_fstat as sampled one cycle earlier. Writes to them and to either receive port are ignored and raise no error.
- R9: A write to the 8-bit transmit port loads the transmit holding register with the low 8 bits and clears the upper byte. A write to the 16-bit port loads all 16 bits. tx_valid pulses for one cycle after either write, and tx_data holds the value afterwards.
- R10: Reads of either transmit port return 0. Reads of either receive port return the receive holding register, which loads hw_rx_data when hw_rx_load is high.
- R11: irq is a register that goes high one cycle after any bit of (interrupt status AND interrupt mask) is set, and goes low one cycle after none is set.
- R12: bus_rdata and bus_err are registered one cycle after the access. bus_rdata is 0 in any cycle that follows no read. Synchronous active-high rst clears every register and output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | Access size code (1 = 16 bits) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | Registered illegal-access pulse |
| hw_int_set | input | DATA_W | Interrupt status set pulses |
| hw_mstat_set | input | DATA_W | Master status set pulses (bits 11:0 used) |
| hw_mstat_live | input | 4 | Live engine state for master status bits 15:12 |
| hw_sstat | input | DATA_W | Slave status from the engine |
| hw_fstat | input | DATA_W | FIFO status from the engine |
| hw_rx_load | input | 1 | Load strobe for the receive holding register |
| hw_rx_data | input | DATA_W | Received word |
| tx_data | output | DATA_W | Transmit holding register |
| tx_valid | output | 1 | Pulse after a transmit port write |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume the bus strobes are clean single-cycle levels sampled at the rising edge, with address and size stable while a strobe is high. They also assume the engine-side set pulses and live status are synchronous to the same clock. The stimulus changes every input on the falling edge and raises only one of the two strobes in any cycle, so a read never overlaps a write to the same slot. Hardware set pulses are applied for exactly one cycle. The single deliberate overlap is a set and a clear of the same bits, used to check the set-wins rule.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int NUM_CSR   = 12;
  localparam int GAP_WORDS = 20;
  localparam int NUM_PORT  = 4;
  localparam int NUM_SLOT  = NUM_CSR + NUM_PORT;
  localparam int STRIDE    = 4;
  localparam int NUM_PLAIN = 8;
  localparam int SLOT_W    = $clog2(NUM_SLOT);

  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam int S_DIV   = 0;
  localparam int S_CTRL  = 1;
  localparam int S_SCTL  = 2;
  localparam int S_SSTAT = 3;
  localparam int S_SADR  = 4;
  localparam int S_MCTL  = 5;
  localparam int S_MSTAT = 6;
  localparam int S_MADR  = 7;
  localparam int S_ISTAT = 8;
  localparam int S_IMASK = 9;
  localparam int S_FCTL  = 10;
  localparam int S_FSTAT = 11;
  localparam int S_TX8   = 12;
  localparam int S_TX16  = 13;
  localparam int S_RX8   = 14;
  localparam int S_RX16  = 15;

  function automatic int slot_offset(input int i);
    if (i < NUM_CSR) return i * STRIDE;
    return (i + GAP_WORDS) * STRIDE;
  endfunction

  function automatic int plain_slot(input int k);
    case (k)
      0: return S_DIV;
      1: return S_CTRL;
      2: return S_SCTL;
      3: return S_SADR;
      4: return S_MCTL;
      5: return S_MADR;
      6: return S_IMASK;
      default: return S_FCTL;
    endcase
  endfunction
endpackage

// File: rtl/tw_addr_decode.sv
module tw_addr_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_SLOT = tw_pkg::NUM_SLOT,
  localparam int IDX_W   = $clog2(NUM_SLOT)
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_SLOT-1:0] sel,
  output logic                hit,
  output logic [IDX_W-1:0]    idx
);
  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(tw_pkg::slot_offset(i));
    assign sel[i] = (addr == OFS);
  end

  assign hit = |sel;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_SLOT; i++) begin
      if (sel[i]) idx = IDX_W'(i);
    end
  end

  always_comb begin
    AST_SEL_ONEHOT: assert ($onehot0(sel)); // R1
  end
endmodule

// File: rtl/tw_plain_bank.sv
module tw_plain_bank #(
  parameter int NUM    = 8,
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM-1:0]             wr_sel,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM-1:0][DATA_W-1:0] q
);
  for (genvar k = 0; k < NUM; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)            q[k] <= '0;
      else if (wr_sel[k]) q[k] <= wdata;
    end

    AST_PLAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wr_sel[k] |=> $stable(q[k])); // R4
  end
endmodule

// File: rtl/tw_sticky_reg.sv
module tw_sticky_reg #(
  parameter int          DATA_W = 16,
  parameter logic [15:0] PROT   = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_val,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] live_i,
  output logic [DATA_W-1:0] q
);
  localparam logic [DATA_W-1:0] PMASK = DATA_W'(PROT);

  logic [DATA_W-1:0] clr_mask;
  logic [DATA_W-1:0] sticky_nxt;

  assign clr_mask   = clr_en ? clr_val : '0;
  assign sticky_nxt = ((q & ~clr_mask) | set_i) & ~PMASK;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= sticky_nxt | (live_i & PMASK);
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((q & $past(set_i) & ~PMASK) == ($past(set_i) & ~PMASK))); // R7

  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!clr_en && set_i == '0) |=> ((q & ~PMASK) == ($past(q) & ~PMASK))); // R5

  AST_PROT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & PMASK) == ($past(live_i) & PMASK))); // R6
endmodule

// File: rtl/tw_reg_front.sv
module tw_reg_front
  import tw_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int LIVE_W   = 4,
  parameter int LIVE_LSB = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic [DATA_W-1:0] hw_int_set,
  input  logic [DATA_W-1:0] hw_mstat_set,
  input  logic [LIVE_W-1:0] hw_mstat_live,
  input  logic [DATA_W-1:0] hw_sstat,
  input  logic [DATA_W-1:0] hw_fstat,
  input  logic              hw_rx_load,
  input  logic [DATA_W-1:0] hw_rx_data,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              irq
);
  localparam logic [15:0] MST_PROT = 16'(((1 << LIVE_W) - 1) << LIVE_LSB);

  logic [NUM_SLOT-1:0] sel;
  logic                hit;
  logic [SLOT_W-1:0]   idx;
  logic                acc_ok;
  logic                wr_ok;
  logic                rd_ok;

  tw_addr_decode #(.ADDR_W(ADDR_W), .NUM_SLOT(NUM_SLOT)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .hit  (hit),
    .idx  (idx)
  );

  assign acc_ok = hit && (bus_size == SZ_HALF);
  assign wr_ok  = bus_wr && acc_ok;
  assign rd_ok  = bus_rd && acc_ok;

  // ordinary read/write registers
  logic [NUM_PLAIN-1:0]             plain_wr;
  logic [NUM_PLAIN-1:0][DATA_W-1:0] plain_q;

  for (genvar k = 0; k < NUM_PLAIN; k++) begin : g_pwr
    assign plain_wr[k] = wr_ok && sel[plain_slot(k)];
  end

  tw_plain_bank #(.NUM(NUM_PLAIN), .DATA_W(DATA_W)) u_plain (
    .clk    (clk),
    .rst    (rst),
    .wr_sel (plain_wr),
    .wdata  (bus_wdata),
    .q      (plain_q)
  );

  // sticky status registers
  logic [DATA_W-1:0] istat_q;
  logic [DATA_W-1:0] mstat_q;
  logic [DATA_W-1:0] live_vec;

  assign live_vec = DATA_W'(hw_mstat_live) << LIVE_LSB;

  tw_sticky_reg #(.DATA_W(DATA_W), .PROT(16'h0000)) u_istat (
    .clk     (clk),
    .rst     (rst),
    .clr_en  (wr_ok && sel[S_ISTAT]),
    .clr_val (bus_wdata),
    .set_i   (hw_int_set),
    .live_i  ('0),
    .q       (istat_q)
  );

  tw_sticky_reg #(.DATA_W(DATA_W), .PROT(MST_PROT)) u_mstat (
    .clk     (clk),
    .rst     (rst),
    .clr_en  (wr_ok && sel[S_MSTAT]),
    .clr_val (bus_wdata),
    .set_i   (hw_mstat_set),
    .live_i  (live_vec),
    .q       (mstat_q)
  );

  // read-only mirrors and holding registers
  logic [DATA_W-1:0] sstat_q;
  logic [DATA_W-1:0] fstat_q;
  logic [DATA_W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sstat_q <= '0;
      fstat_q <= '0;
      rx_q    <= '0;
    end else begin
      sstat_q <= hw_sstat;
      fstat_q <= hw_fstat;
      if (hw_rx_load) rx_q <= hw_rx_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data  <= '0;
      tx_valid <= 1'b0;
    end else begin
      tx_valid <= wr_ok && (sel[S_TX8] || sel[S_TX16]);
      if (wr_ok && sel[S_TX8])
        tx_data <= {{(DATA_W-8){1'b0}}, bus_wdata[7:0]};
      else if (wr_ok && sel[S_TX16])
        tx_data <= bus_wdata;
    end
  end

  // read view
  logic [DATA_W-1:0] view [NUM_SLOT];

  always_comb begin
    for (int i = 0; i < NUM_SLOT; i++) view[i] = '0;
    for (int k = 0; k < NUM_PLAIN; k++) view[plain_slot(k)] = plain_q[k];
    view[S_SSTAT] = sstat_q;
    view[S_FSTAT] = fstat_q;
    view[S_ISTAT] = istat_q;
    view[S_MSTAT] = mstat_q;
    view[S_RX8]   = rx_q;
    view[S_RX16]  = rx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_ok ? view[idx] : '0;
      bus_err   <= (bus_wr || bus_rd) && !acc_ok;
      irq       <= |(istat_q & plain_q[6]);
    end
  end

  AST_BAD_SIZE_FLAG: assert property (@(posedge clk) disable iff (rst)
    ((bus_wr || bus_rd) && bus_size != SZ_HALF) |=> (bus_err && bus_rdata == '0)); // R2

  AST_BAD_NO_TX: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !acc_ok) |=> (!tx_valid && $stable(tx_data))); // R3

  AST_TX_BYTE: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && sel[S_TX8]) |=> (tx_valid && tx_data[DATA_W-1:8] == '0)); // R9

  AST_TX_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (sel[S_TX8] || sel[S_TX16])) |=> (bus_rdata == '0)); // R10

  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0)); // R12
endmodule

// File: tb/tw_reg_front_bench.sv
module tw_reg_front_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic [1:0]  bus_size;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_err;
  logic [15:0] hw_int_set, hw_mstat_set, hw_sstat, hw_fstat, hw_rx_data;
  logic [3:0]  hw_mstat_live;
  logic        hw_rx_load;
  logic [15:0] tx_data;
  logic        tx_valid;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  tw_reg_front u_tw_reg_front (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .hw_int_set(hw_int_set),
    .hw_mstat_set(hw_mstat_set), .hw_mstat_live(hw_mstat_live),
    .hw_sstat(hw_sstat), .hw_fstat(hw_fstat), .hw_rx_load(hw_rx_load),
    .hw_rx_data(hw_rx_data), .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq)
  );

  // vector: wr, rd, addr, size, wdata, expected rdata, expected err, requirement
  localparam int NV = 29;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1,1'b0,8'h00,2'd1,16'h1234,16'h0000,1'b0,4'd4},  // R4 clock divider
    {1'b0,1'b1,8'h00,2'd1,16'h0000,16'h1234,1'b0,4'd4},
    {1'b1,1'b0,8'h04,2'd1,16'hA5A5,16'h0000,1'b0,4'd4},  // R4 control
    {1'b0,1'b1,8'h04,2'd1,16'h0000,16'hA5A5,1'b0,4'd4},
    {1'b1,1'b0,8'h08,2'd1,16'h00C3,16'h0000,1'b0,4'd1},  // R1 slave control
    {1'b0,1'b1,8'h08,2'd1,16'h0000,16'h00C3,1'b0,4'd1},
    {1'b1,1'b0,8'h10,2'd1,16'h7E01,16'h0000,1'b0,4'd1},  // R1 slave address
    {1'b0,1'b1,8'h10,2'd1,16'h0000,16'h7E01,1'b0,4'd1},
    {1'b1,1'b0,8'h14,2'd1,16'h3333,16'h0000,1'b0,4'd4},  // R4 master control
    {1'b0,1'b1,8'h14,2'd1,16'h0000,16'h3333,1'b0,4'd4},
    {1'b1,1'b0,8'h1C,2'd1,16'h0055,16'h0000,1'b0,4'd4},  // R4 master address
    {1'b0,1'b1,8'h1C,2'd1,16'h0000,16'h0055,1'b0,4'd4},
    {1'b1,1'b0,8'h28,2'd1,16'h0F0F,16'h0000,1'b0,4'd4},  // R4 FIFO control
    {1'b0,1'b1,8'h28,2'd1,16'h0000,16'h0F0F,1'b0,4'd4},
    {1'b1,1'b0,8'h0C,2'd1,16'hFFFF,16'h0000,1'b0,4'd8},  // R8 slave status RO
    {1'b0,1'b1,8'h0C,2'd1,16'h0000,16'h0F0F,1'b0,4'd8},
    {1'b1,1'b0,8'h2C,2'd1,16'h1111,16'h0000,1'b0,4'd8},  // R8 FIFO status RO
    {1'b0,1'b1,8'h2C,2'd1,16'h0000,16'h0042,1'b0,4'd8},
    {1'b0,1'b1,8'h80,2'd1,16'h0000,16'h0000,1'b0,4'd10}, // R10 tx reads zero
    {1'b0,1'b1,8'h84,2'd1,16'h0000,16'h0000,1'b0,4'd10},
    {1'b0,1'b1,8'h30,2'd1,16'h0000,16'h0000,1'b1,4'd3},  // R3 gap
    {1'b1,1'b0,8'h7C,2'd1,16'hDEAD,16'h0000,1'b1,4'd3},
    {1'b0,1'b1,8'h90,2'd1,16'h0000,16'h0000,1'b1,4'd3},
    {1'b0,1'b1,8'h02,2'd1,16'h0000,16'h0000,1'b1,4'd3},  // R3 misaligned
    {1'b1,1'b0,8'h00,2'd0,16'hFFFF,16'h0000,1'b1,4'd2},  // R2 byte write dropped
    {1'b0,1'b1,8'h00,2'd1,16'h0000,16'h1234,1'b0,4'd2},
    {1'b0,1'b1,8'h00,2'd2,16'h0000,16'h0000,1'b1,4'd2},  // R2 word read
    {1'b1,1'b0,8'h88,2'd1,16'h9999,16'h0000,1'b0,4'd8},  // R8 rx write ignored
    {1'b0,1'b1,8'h88,2'd1,16'h0000,16'h0000,1'b0,4'd8}
  };

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic rd, input logic [7:0] a,
                        input logic [1:0] sz, input logic [15:0] wd);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_size = sz; bus_wdata = wd;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic read_chk(input logic [7:0] a, input logic [15:0] exp, input string req);
    access(1'b0, 1'b1, a, 2'd1, 16'h0);
    check(req, $sformatf("read %h", a), bus_rdata, exp);
  endtask

  task automatic wr16(input logic [7:0] a, input logic [15:0] d);
    access(1'b1, 1'b0, a, 2'd1, d);
  endtask

  task automatic pulse_int(input logic [15:0] v);
    @(negedge clk); hw_int_set = v;
    @(negedge clk); hw_int_set = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_size = 2'd1; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    hw_int_set = '0; hw_mstat_set = '0; hw_mstat_live = 4'b1010;
    hw_sstat = 16'h0F0F; hw_fstat = 16'h0042; hw_rx_load = 0; hw_rx_data = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "rdata in reset", bus_rdata, 16'h0);
    check("R12", "err/irq/tx_valid in reset", {13'h0, bus_err, irq, tx_valid}, 16'h0);
    check("R12", "tx_data in reset", tx_data, 16'h0);
    rst = 1'b0;
    read_chk(8'h00, 16'h0000, "R12");
    check("R12", "rdata idle after read", bus_rdata, 16'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][48], VEC[i][47], VEC[i][46:39], VEC[i][38:37], VEC[i][36:21]);
      check($sformatf("R%0d", VEC[i][3:0]), $sformatf("vec %0d rdata", i), bus_rdata, VEC[i][20:5]);
      check($sformatf("R%0d", VEC[i][3:0]), $sformatf("vec %0d err", i), {15'h0, bus_err}, {15'h0, VEC[i][4]});
    end

    // R5 interrupt status clear-on-one
    pulse_int(16'h0005);
    read_chk(8'h20, 16'h0005, "R5");
    wr16(8'h20, 16'h0001);
    read_chk(8'h20, 16'h0004, "R5");
    wr16(8'h20, 16'h0000);
    read_chk(8'h20, 16'h0004, "R5");

    // R7 set beats clear in the same cycle
    @(negedge clk);
    hw_int_set = 16'h0003; bus_wr = 1; bus_addr = 8'h20; bus_size = 2'd1; bus_wdata = 16'h0001;
    @(negedge clk);
    hw_int_set = '0; bus_wr = 0;
    read_chk(8'h20, 16'h0007, "R7");
    wr16(8'h20, 16'h0007);
    read_chk(8'h20, 16'h0000, "R5");

    // R11 interrupt line
    pulse_int(16'h0004);
    @(negedge clk);
    check("R11", "irq masked", {15'h0, irq}, 16'h0);
    wr16(8'h24, 16'h0004);
    @(negedge clk);
    check("R11", "irq unmasked", {15'h0, irq}, 16'h1);
    wr16(8'h20, 16'h0004);
    @(negedge clk);
    check("R11", "irq after clear", {15'h0, irq}, 16'h0);

    // R6 master status with protected bits
    @(negedge clk); hw_mstat_set = 16'hF0FF;
    @(negedge clk); hw_mstat_set = '0;
    read_chk(8'h18, 16'hA0FF, "R6");
    wr16(8'h18, 16'hFFFF);
    read_chk(8'h18, 16'hA000, "R6");
    @(negedge clk); hw_mstat_live = 4'b0101;
    @(negedge clk);
    read_chk(8'h18, 16'h5000, "R6");

    // R9 transmit ports
    wr16(8'h80, 16'hBEEF);
    check("R9", "tx8 data", tx_data, 16'h00EF);
    check("R9", "tx8 valid", {15'h0, tx_valid}, 16'h1);
    @(negedge clk);
    check("R9", "tx valid drops", {15'h0, tx_valid}, 16'h0);
    check("R9", "tx data holds", tx_data, 16'h00EF);
    wr16(8'h84, 16'hBEEF);
    check("R9", "tx16 data", tx_data, 16'hBEEF);

    // R10 receive ports
    @(negedge clk); hw_rx_load = 1; hw_rx_data = 16'hC3D2;
    @(negedge clk); hw_rx_load = 0; hw_rx_data = 16'h1111;
    read_chk(8'h88, 16'hC3D2, "R10");
    read_chk(8'h8C, 16'hC3D2, "R10");

    // R12 reset in the middle of a run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    read_chk(8'h00, 16'h0000, "R12");
    read_chk(8'h1C, 16'h0000, "R12");
    check("R12", "tx_data after reset", tx_data, 16'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule